// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block is the arbitration core of an interrupt controller. It latches requests from a set of peripheral sources into pending flags and holds a priority for each source. It picks the most urgent enabled pending source and asks the CPU to preempt only when that candidate belongs to a strictly more urgent preemption group than the context now running. Three fixed, non-maskable exception levels sit above every configurable priority.

On acknowledge, the winner becomes the running context and the previous context is pushed onto an internal stack. On exception return, the stack is popped and arbitration resumes from the restored level in the next cycle. A request that was blocked by the inner context can therefore be taken straight away, without first unwinding to thread level. Register stacking, vector fetch and the CPU itself lie outside the block.

Top module: `nest_irq_arbiter`

## Requirements
- R1: A priority write keeps only the upper IMPL_BITS (default 4) bits of the 8-bit value. Reading a priority through `rd_idx_i`/`rd_prio_o` returns those bits with the lower bits reading as zero.
- R2: With HI_IS_URGENT=0, a smaller priority value is more urgent. With HI_IS_URGENT=1, a larger value is more urgent, and selection and nesting both follow that convention.
- R3: A split write (`wr_op_i`=4) sets how many of the implemented bits, counted from the urgent end of the normalised value, form the preemption group. The remaining bits form the subpriority. Values above IMPL_BITS are clamped to IMPL_BITS, which is also the reset value.
- R4: `preempt_o` is high only when the candidate's rank is strictly lower (more urgent) than `run_rank_o`. A candidate in the same group with a better subpriority never preempts.
- R5: Among enabled pending sources, the candidate is the one with the lowest rank, then the lowest subpriority, then the lowest source index.
- R6: A level source (EDGE_MASK bit 0) sets its pending flag every cycle its request is high. An edge source sets it only on a rising edge. A set-pending write (`wr_op_i`=2) also sets the flag. The flag holds until a clear-pending write (`wr_op_i`=3) or an acknowledge clears it. A hardware set in the same cycle wins over a clear.
- R7: A disabled source (enable write `wr_op_i`=1, data bit 0) can still become pending but is never selected.
- R8: Fixed request bit k (k=0..2) has rank k and vector k. Bit 0 is the most urgent. These levels outrank every source, have no priority register, and cannot preempt a context of equal or higher urgency.
- R9: An acknowledge while `preempt_o` is high pushes the running rank and vector and makes the candidate the running context. For a source, it also clears the pending flag and sets the active bit. An acknowledge while `preempt_o` is low has no effect.
- R10: An exception return pops the stack, clears the active bit of the context that was running, and re-evaluates the pending sources from the restored rank. A return with an empty stack is ignored. A return in the same cycle as an acknowledge blocks the acknowledge.
- R11: Source i has vector i+3. A source rank is 3 plus its preemption group. The idle rank is 2^IMPL_BITS+3 (19 by default).
- R12: After reset, all priorities, enables, pending and active bits are zero, the running rank is idle, the running vector is 0 and `preempt_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Peripheral request lines |
| fixed_i | input | 3 | Non-maskable requests, bit 0 most urgent |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 3 | 0 priority, 1 enable, 2 set pending, 3 clear pending, 4 group split |
| wr_idx_i | input | IDX_W | Source addressed by the write |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | IDX_W | Source whose priority is read |
| rd_prio_o | output | 8 | Stored priority of the addressed source |
| ack_i | input | 1 | CPU accepts the offered preemption |
| eret_i | input | 1 | CPU returns from the running exception |
| preempt_o | output | 1 | Preemption request to the CPU |
| vec_o | output | VEC_W | Vector of the current candidate |
| run_rank_o | output | RANK_W | Rank of the running context |
| run_vec_o | output | VEC_W | Vector of the running context |
| pend_o | output | NUM_SRC | Pending flags |
| active_o | output | NUM_SRC | Active flags |

## Verification
The assertions assume the CPU issues returns only for contexts it has entered, that every input is synchronous to the clock, and that inputs are never unknown after reset. A fixed request is assumed to be either taken or withdrawn, and never left high while a return restores a less urgent level. The stimulus changes inputs one step after each clock edge. It issues an acknowledge only after it has seen the offer it expects, and it pairs every return with an earlier acknowledge. The only exception is one deliberate return at idle, which checks that such a return is ignored.

// File: rtl/nia_pkg.sv
`timescale 1ns/1ps
package nia_pkg;
  localparam int NUM_FIXED = 3;

  typedef enum logic [2:0] {
    OP_PRIO  = 3'd0,
    OP_EN    = 3'd1,
    OP_SETP  = 3'd2,
    OP_CLRP  = 3'd3,
    OP_SPLIT = 3'd4
  } wr_op_e;
endpackage

// File: rtl/nia_src_bank.sv
`timescale 1ns/1ps
module nia_src_bank
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IMPL_BITS = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  parameter int IDX_W = 3,
  parameter int SPLIT_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0]                irq_i,
  input  logic                              wr_en_i,
  input  logic [2:0]                        wr_op_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [7:0]                        wr_data_i,
  input  logic                              ack_clr_i,
  input  logic [IDX_W-1:0]                  ack_idx_i,
  input  logic [IDX_W-1:0]                  rd_idx_i,
  output logic [NUM_SRC-1:0][IMPL_BITS-1:0] prio_o,
  output logic [NUM_SRC-1:0]                en_o,
  output logic [NUM_SRC-1:0]                pend_o,
  output logic [SPLIT_W-1:0]                split_o,
  output logic [7:0]                        rd_prio_o
);
  localparam int LOW_BITS = 8 - IMPL_BITS;

  logic [SPLIT_W-1:0] split_q, split_d;
  logic               split_we;

  assign split_we = wr_en_i && (wr_op_i == OP_SPLIT);

  always_comb begin
    if (wr_data_i > 8'(IMPL_BITS)) split_d = SPLIT_W'(IMPL_BITS);
    else                           split_d = wr_data_i[SPLIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        split_q <= SPLIT_W'(IMPL_BITS);
    else if (split_we) split_q <= split_d;
  end

  assign split_o = split_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic                 hit, prio_we, en_we, hw_set;
    logic                 pend_q, pend_d, en_q;
    logic [IMPL_BITS-1:0] prio_q;

    assign hit     = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign prio_we = hit && (wr_op_i == OP_PRIO);
    assign en_we   = hit && (wr_op_i == OP_EN);

    if (EDGE_MASK[g]) begin : g_edge
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_i[g];
      end
      assign hw_set = irq_i[g] & ~irq_q;
    end else begin : g_level
      assign hw_set = irq_i[g];
    end

    always_comb begin
      pend_d = pend_q;
      if ((hit && wr_op_i == OP_CLRP) || (ack_clr_i && ack_idx_i == IDX_W'(g)))
        pend_d = 1'b0;
      if (hit && wr_op_i == OP_SETP)
        pend_d = 1'b1;
      if (hw_set)
        pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
        prio_q <= '0;
      end else begin
        pend_q <= pend_d;
        if (en_we)   en_q   <= wr_data_i[0];
        if (prio_we) prio_q <= wr_data_i[7 -: IMPL_BITS];
      end
    end

    assign prio_o[g] = prio_q;
    assign en_o[g]   = en_q;
    assign pend_o[g] = pend_q;
  end

  assign rd_prio_o = {prio_o[rd_idx_i], {LOW_BITS{1'b0}}};
endmodule

// File: rtl/nia_select.sv
`timescale 1ns/1ps
module nia_select
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IMPL_BITS = 4,
  parameter bit HI_IS_URGENT = 1'b0,
  parameter int IDX_W = 3,
  parameter int VEC_W = 4,
  parameter int RANK_W = 5,
  parameter int SPLIT_W = 3
) (
  input  logic [NUM_SRC-1:0][IMPL_BITS-1:0] prio_i,
  input  logic [NUM_SRC-1:0]                en_i,
  input  logic [NUM_SRC-1:0]                pend_i,
  input  logic [NUM_FIXED-1:0]              fixed_i,
  input  logic [SPLIT_W-1:0]                split_i,
  output logic                              cand_valid_o,
  output logic [RANK_W-1:0]                 cand_rank_o,
  output logic [VEC_W-1:0]                  cand_vec_o,
  output logic                              cand_is_src_o,
  output logic [IDX_W-1:0]                  cand_src_o
);
  logic [IMPL_BITS-1:0] norm, grp, sub, best_sub;
  logic [RANK_W-1:0]    rank;
  int                   sh;

  always_comb begin
    cand_valid_o  = 1'b0;
    cand_rank_o   = '1;
    cand_vec_o    = '0;
    cand_is_src_o = 1'b0;
    cand_src_o    = '0;
    best_sub      = '1;
    sh            = IMPL_BITS - int'(split_i);
    norm          = '0;
    grp           = '0;
    sub           = '0;
    rank          = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      norm = HI_IS_URGENT ? ~prio_i[i] : prio_i[i];
      grp  = norm >> sh;
      sub  = norm & IMPL_BITS'((1 << sh) - 1);
      rank = RANK_W'(grp) + RANK_W'(NUM_FIXED);
      if (pend_i[i] && en_i[i] &&
          (!cand_valid_o || {rank, sub} < {cand_rank_o, best_sub})) begin
        cand_valid_o  = 1'b1;
        cand_rank_o   = rank;
        best_sub      = sub;
        cand_vec_o    = VEC_W'(i + NUM_FIXED);
        cand_is_src_o = 1'b1;
        cand_src_o    = IDX_W'(i);
      end
    end
    for (int k = NUM_FIXED - 1; k >= 0; k--) begin
      if (fixed_i[k]) begin
        cand_valid_o  = 1'b1;
        cand_rank_o   = RANK_W'(k);
        best_sub      = '0;
        cand_vec_o    = VEC_W'(k);
        cand_is_src_o = 1'b0;
        cand_src_o    = '0;
      end
    end
  end
endmodule

// File: rtl/nia_nest_stack.sv
`timescale 1ns/1ps
module nia_nest_stack
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = 3,
  parameter int VEC_W = 4,
  parameter int RANK_W = 5,
  parameter int STK_DEPTH = 19,
  parameter int SP_W = 5,
  parameter int IDLE_RANK = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               ret_i,
  input  logic [RANK_W-1:0]  new_rank_i,
  input  logic [VEC_W-1:0]   new_vec_i,
  input  logic               new_is_src_i,
  input  logic [IDX_W-1:0]   new_src_i,
  output logic [RANK_W-1:0]  run_rank_o,
  output logic [VEC_W-1:0]   run_vec_o,
  output logic [NUM_SRC-1:0] active_o,
  output logic [SP_W-1:0]    depth_o
);
  localparam int ENT_W = RANK_W + VEC_W;

  logic [ENT_W-1:0]   stk_q [STK_DEPTH];
  logic [ENT_W-1:0]   tos;
  logic               stk_we;
  logic [RANK_W-1:0]  rank_q, rank_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic [SP_W-1:0]    sp_q, sp_d;
  logic [NUM_SRC-1:0] act_q, act_d;

  assign tos = (sp_q != '0) ? stk_q[sp_q - SP_W'(1)] : '0;

  always_comb begin
    rank_d = rank_q;
    vec_d  = vec_q;
    sp_d   = sp_q;
    act_d  = act_q;
    stk_we = 1'b0;
    if (ret_i) begin
      rank_d = tos[ENT_W-1 -: RANK_W];
      vec_d  = tos[VEC_W-1:0];
      sp_d   = sp_q - SP_W'(1);
      if (vec_q >= VEC_W'(NUM_FIXED))
        act_d[IDX_W'(vec_q - VEC_W'(NUM_FIXED))] = 1'b0;
    end else if (take_i) begin
      stk_we = 1'b1;
      rank_d = new_rank_i;
      vec_d  = new_vec_i;
      sp_d   = sp_q + SP_W'(1);
      if (new_is_src_i) act_d[new_src_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= RANK_W'(IDLE_RANK);
      vec_q  <= '0;
      sp_q   <= '0;
      act_q  <= '0;
    end else begin
      rank_q <= rank_d;
      vec_q  <= vec_d;
      sp_q   <= sp_d;
      act_q  <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (stk_we) stk_q[sp_q] <= {rank_q, vec_q};
  end

  assign run_rank_o = rank_q;
  assign run_vec_o  = vec_q;
  assign active_o   = act_q;
  assign depth_o    = sp_q;
endmodule

// File: rtl/nest_irq_arbiter.sv
`timescale 1ns/1ps
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IMPL_BITS = 4,
  parameter bit HI_IS_URGENT = 1'b0,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'hF0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int VEC_W = $clog2(NUM_SRC + NUM_FIXED),
  localparam int NUM_GRP = 2 ** IMPL_BITS,
  localparam int IDLE_RANK = NUM_GRP + NUM_FIXED,
  localparam int RANK_W = $clog2(IDLE_RANK + 1),
  localparam int SPLIT_W = $clog2(IMPL_BITS + 1),
  localparam int STK_DEPTH = NUM_GRP + NUM_FIXED,
  localparam int SP_W = $clog2(STK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_i,
  input  logic [2:0]           fixed_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_op_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [7:0]           rd_prio_o,
  input  logic                 ack_i,
  input  logic                 eret_i,
  output logic                 preempt_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [RANK_W-1:0]    run_rank_o,
  output logic [VEC_W-1:0]     run_vec_o,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic [NUM_SRC-1:0]   active_o
);
  logic [NUM_SRC-1:0][IMPL_BITS-1:0] prio_w;
  logic [NUM_SRC-1:0]                en_w;
  logic [SPLIT_W-1:0]                split_w;
  logic                              cand_valid, cand_is_src, take, ret;
  logic [RANK_W-1:0]                 cand_rank;
  logic [VEC_W-1:0]                  cand_vec;
  logic [IDX_W-1:0]                  cand_src;
  logic [SP_W-1:0]                   depth_w;

  nia_src_bank #(
    .NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS), .EDGE_MASK(EDGE_MASK),
    .IDX_W(IDX_W), .SPLIT_W(SPLIT_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .wr_en_i(wr_en_i), .wr_op_i(wr_op_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .ack_clr_i(take && cand_is_src), .ack_idx_i(cand_src), .rd_idx_i(rd_idx_i),
    .prio_o(prio_w), .en_o(en_w), .pend_o(pend_o), .split_o(split_w),
    .rd_prio_o(rd_prio_o)
  );

  nia_select #(
    .NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS), .HI_IS_URGENT(HI_IS_URGENT),
    .IDX_W(IDX_W), .VEC_W(VEC_W), .RANK_W(RANK_W), .SPLIT_W(SPLIT_W)
  ) u_sel (
    .prio_i(prio_w), .en_i(en_w), .pend_i(pend_o), .fixed_i(fixed_i), .split_i(split_w),
    .cand_valid_o(cand_valid), .cand_rank_o(cand_rank), .cand_vec_o(cand_vec),
    .cand_is_src_o(cand_is_src), .cand_src_o(cand_src)
  );

  assign preempt_o = cand_valid && (cand_rank < run_rank_o);
  assign vec_o     = cand_vec;
  assign ret       = eret_i && (depth_w != '0);
  assign take      = ack_i && preempt_o && !eret_i;

  nia_nest_stack #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .RANK_W(RANK_W),
    .STK_DEPTH(STK_DEPTH), .SP_W(SP_W), .IDLE_RANK(IDLE_RANK)
  ) u_stack (
    .clk(clk), .rst_n(rst_n), .take_i(take), .ret_i(ret),
    .new_rank_i(cand_rank), .new_vec_i(cand_vec), .new_is_src_i(cand_is_src),
    .new_src_i(cand_src), .run_rank_o(run_rank_o), .run_vec_o(run_vec_o),
    .active_o(active_o), .depth_o(depth_w)
  );
endmodule

// File: rtl/nia_chk.sv
`timescale 1ns/1ps
module nia_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = 3,
  parameter int VEC_W = 4,
  parameter int RANK_W = 5,
  parameter int SP_W = 5,
  parameter int IDLE_RANK = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_i,
  input logic               eret_i,
  input logic [2:0]         fixed_i,
  input logic               preempt_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [RANK_W-1:0]  run_rank_o,
  input logic [NUM_SRC-1:0] active_o,
  input logic [NUM_SRC-1:0] en,
  input logic [SP_W-1:0]    depth
);
  logic [IDX_W-1:0] vsrc;
  assign vsrc = IDX_W'(vec_o - VEC_W'(3));

  // R9
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && preempt_o && !eret_i) |=> (run_rank_o < $past(run_rank_o)));

  // R10
  eret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && depth != '0) |=> (run_rank_o > $past(run_rank_o)));

  // R8
  fixed_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_i != 3'b000 && run_rank_o > RANK_W'(2)) |-> (preempt_o && vec_o < VEC_W'(3)));

  // R4
  top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_rank_o == '0) |-> !preempt_o);

  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_o && vec_o >= VEC_W'(3)) |-> en[vsrc]);

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (active_o == '0 && run_rank_o == RANK_W'(IDLE_RANK)));

  // R9
  active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_o) <= int'(depth));
endmodule

bind nest_irq_arbiter nia_chk #(
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W), .RANK_W(RANK_W),
  .SP_W(SP_W), .IDLE_RANK(IDLE_RANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eret_i(eret_i), .fixed_i(fixed_i),
  .preempt_o(preempt_o), .vec_o(vec_o), .run_rank_o(run_rank_o),
  .active_o(active_o), .en(en_w), .depth(depth_w)
);

// File: tb/nest_irq_arbiter_test.sv
`timescale 1ns/1ps
module nest_irq_arbiter_test;
  localparam int N = 8;
  localparam logic [2:0] W_PRIO = 3'd0, W_EN = 3'd1, W_SETP = 3'd2, W_CLRP = 3'd3, W_SPLIT = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [N-1:0] irq;
  logic [2:0] fixed, wr_op;
  logic       wr_en, ack, eret;
  logic [2:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_prio, rd_prio_r;
  logic       preempt, preempt_r;
  logic [3:0] vec, run_vec, vec_r, run_vec_r;
  logic [4:0] run_rank, run_rank_r;
  logic [N-1:0] pend, active, pend_r, active_r;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nest_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .fixed_i(fixed),
    .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_prio_o(rd_prio), .ack_i(ack), .eret_i(eret),
    .preempt_o(preempt), .vec_o(vec), .run_rank_o(run_rank), .run_vec_o(run_vec),
    .pend_o(pend), .active_o(active)
  );

  nest_irq_arbiter #(.HI_IS_URGENT(1'b1)) uut_rev (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .fixed_i(fixed),
    .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_prio_o(rd_prio_r), .ack_i(ack), .eret_i(eret),
    .preempt_o(preempt_r), .vec_o(vec_r), .run_rank_o(run_rank_r), .run_vec_o(run_vec_r),
    .pend_o(pend_r), .active_o(active_r)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] op, input int idx, input int data);
    wr_en = 1'b1; wr_op = op; wr_idx = 3'(idx); wr_data = 8'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_eret();
    eret = 1'b1; tick(); eret = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; fixed = '0; wr_en = 1'b0; wr_op = '0; wr_idx = '0;
    wr_data = '0; rd_idx = '0; ack = 1'b0; eret = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12", "preempt", int'(preempt), 0);
    chk("R12", "run_rank", int'(run_rank), 19);
    chk("R12", "run_vec", int'(run_vec), 0);
    chk("R12", "pend", int'(pend), 0);
    chk("R12", "active", int'(active), 0);
    chk("R12", "prio0", int'(rd_prio), 0);
  endtask

  task automatic t_prio_rw();
    do_reset();
    wr(W_PRIO, 2, 8'hAB);
    rd_idx = 3'd2; #1;
    chk("R1", "prio2 AB", int'(rd_prio), 8'hA0);
    wr(W_PRIO, 5, 8'hFF);
    rd_idx = 3'd5; #1;
    chk("R1", "prio5 FF", int'(rd_prio), 8'hF0);
    wr(W_PRIO, 2, 8'h0F);
    rd_idx = 3'd2; #1;
    chk("R1", "prio2 0F", int'(rd_prio), 0);
  endtask

  task automatic t_pending();
    do_reset();
    irq[4] = 1'b1; tick();
    chk("R6", "edge set", int'(pend[4]), 1);
    wr(W_CLRP, 4, 0);
    chk("R6", "edge clear", int'(pend[4]), 0);
    tick();
    chk("R6", "edge held high no reset", int'(pend[4]), 0);
    irq[4] = 1'b0; tick(); irq[4] = 1'b1; tick();
    chk("R6", "edge second rise", int'(pend[4]), 1);
    irq[4] = 1'b0;
    irq[0] = 1'b1; tick();
    chk("R6", "level set", int'(pend[0]), 1);
    wr(W_CLRP, 0, 0);
    chk("R6", "level set beats clear", int'(pend[0]), 1);
    irq[0] = 1'b0;
    wr(W_CLRP, 0, 0);
    chk("R6", "level clear", int'(pend[0]), 0);
    wr(W_SETP, 3, 0);
    chk("R6", "set op", int'(pend[3]), 1);
    chk("R7", "disabled pending no preempt", int'(preempt), 0);
  endtask

  task automatic t_select();
    do_reset();
    wr(W_PRIO, 1, 8'h30); wr(W_PRIO, 2, 8'h30); wr(W_PRIO, 3, 8'h20);
    for (int i = 1; i <= 3; i++) wr(W_EN, i, 1);
    for (int i = 1; i <= 3; i++) wr(W_SETP, i, 0);
    chk("R5", "preempt", int'(preempt), 1);
    chk("R5", "most urgent vec", int'(vec), 6);
    wr(W_CLRP, 3, 0);
    chk("R5", "tie lowest index", int'(vec), 4);
    wr(W_EN, 1, 0);
    chk("R7", "disabled skipped", int'(vec), 5);
    chk("R7", "disabled still pending", int'(pend[1]), 1);
  endtask

  task automatic t_nest();
    do_reset();
    wr(W_PRIO, 0, 8'h50); wr(W_PRIO, 1, 8'h50); wr(W_PRIO, 2, 8'h30); wr(W_PRIO, 3, 8'h40);
    for (int i = 0; i <= 3; i++) wr(W_EN, i, 1);
    wr(W_SETP, 1, 0);
    chk("R11", "vec src1", int'(vec), 4);
    do_ack();
    chk("R9", "rank after ack", int'(run_rank), 8);
    chk("R9", "run_vec", int'(run_vec), 4);
    chk("R9", "pend cleared", int'(pend[1]), 0);
    chk("R9", "active set", int'(active), 8'h02);
    wr(W_SETP, 0, 0);
    chk("R4", "equal group no preempt", int'(preempt), 0);
    wr(W_SETP, 2, 0);
    chk("R4", "higher group preempts", int'(preempt), 1);
    do_ack();
    chk("R9", "nested rank", int'(run_rank), 6);
    chk("R9", "nested active", int'(active), 8'h06);
    wr(W_SETP, 3, 0);
    chk("R4", "blocked", int'(preempt), 0);
    do_eret();
    chk("R10", "pop rank", int'(run_rank), 8);
    chk("R10", "pop vec", int'(run_vec), 4);
    chk("R10", "active after pop", int'(active), 8'h02);
    chk("R10", "blocked now preempts", int'(preempt), 1);
    chk("R10", "blocked vec", int'(vec), 6);
    do_ack();
    chk("R10", "tail taken rank", int'(run_rank), 7);
    do_ack();
    chk("R9", "ack without offer ignored", int'(run_rank), 7);
    do_eret();
    chk("R4", "src0 equal after pop", int'(preempt), 0);
    do_eret();
    chk("R10", "back to idle", int'(run_rank), 19);
    chk("R10", "idle active", int'(active), 0);
    chk("R10", "src0 offered", int'(vec), 3);
  endtask

  task automatic t_split();
    do_reset();
    wr(W_SPLIT, 0, 2);
    wr(W_PRIO, 0, 8'h40); wr(W_PRIO, 1, 8'h50);
    wr(W_EN, 0, 1); wr(W_EN, 1, 1);
    wr(W_SETP, 1, 0);
    do_ack();
    chk("R3", "two-bit group rank", int'(run_rank), 4);
    wr(W_SETP, 0, 0);
    chk("R4", "better sub no preempt", int'(preempt), 0);
    chk("R5", "better sub selected", int'(vec), 3);
    do_eret();
    chk("R3", "idle offer", int'(preempt), 1);
    wr(W_SPLIT, 0, 7);
    do_ack();
    chk("R3", "clamped split rank", int'(run_rank), 7);
    wr(W_SETP, 1, 0);
    chk("R3", "0x50 now lower group", int'(preempt), 0);
    do_eret();
    chk("R3", "0x50 offered", int'(vec), 4);
  endtask

  task automatic t_fixed();
    do_reset();
    wr(W_EN, 0, 1);
    wr(W_SETP, 0, 0);
    do_ack();
    chk("R11", "most urgent source rank", int'(run_rank), 3);
    fixed = 3'b010; tick();
    chk("R8", "fixed preempts", int'(preempt), 1);
    chk("R8", "fixed vec", int'(vec), 1);
    do_ack();
    chk("R8", "fixed rank", int'(run_rank), 1);
    chk("R8", "fixed no active bit", int'(active), 8'h01);
    fixed = 3'b011; tick();
    chk("R8", "fixed0 over fixed1", int'(vec), 0);
    ack = 1'b1; eret = 1'b1; tick(); ack = 1'b0; eret = 1'b0;
    chk("R10", "return beats ack", int'(run_rank), 3);
    chk("R10", "return vec", int'(run_vec), 3);
    do_ack();
    chk("R8", "fixed0 rank", int'(run_rank), 0);
    fixed = 3'b111; tick();
    chk("R8", "nothing above fixed0", int'(preempt), 0);
    do_eret();
    do_eret();
    chk("R10", "idle after two returns", int'(run_rank), 19);
    do_eret();
    chk("R10", "return at idle ignored", int'(run_rank), 19);
    chk("R10", "idle vec", int'(run_vec), 0);
    fixed = 3'b000;
  endtask

  task automatic t_reverse();
    do_reset();
    wr(W_PRIO, 1, 8'h10); wr(W_PRIO, 2, 8'h20);
    wr(W_EN, 1, 1); wr(W_EN, 2, 1);
    wr(W_SETP, 1, 0); wr(W_SETP, 2, 0);
    chk("R2", "small urgent vec", int'(vec), 4);
    chk("R2", "large urgent vec", int'(vec_r), 5);
    do_ack();
    chk("R2", "small urgent rank", int'(run_rank), 4);
    chk("R2", "large urgent rank", int'(run_rank_r), 16);
  endtask

  initial begin
    t_reset();
    t_prio_rw();
    t_pending();
    t_select();
    t_nest();
    t_split();
    t_fixed();
    t_reverse();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule